// File: doc/BRIEF.md
# Conditional Execute and Writeback Control

This block sits between instruction fetch and the register file of a small 32-bit core. It takes one instruction word per cycle and splits it into its opcode, destination register address, source register address and control bits. It then tests the instruction's own 4-bit condition against the current Zero and Carry flags and decides whether the instruction runs.

From that decision it produces everything the datapath needs to commit the result. It chooses between a source register and a zero-extended 9-bit immediate. It raises a writeback strobe for the destination register. It forms the next Zero and Carry values from the ALU result flags, and each flag has its own enable. A skipped instruction commits nothing and is reported as costing a fixed number of clocks.

All outputs are registered and appear one clock after the instruction is presented. The ALU itself lives elsewhere. Its result flags are expected on the same cycle as the instruction word.

Top module: `cond_exec_ctrl`

## Requirements
- R1: One clock after `in_valid` is high, `out_valid` is high and the outputs carry the fields of that instruction: `opcode` = instr[31:26], `dest_addr` = instr[17:9], `src_addr` = instr[8:0].
- R2: `src_is_imm` equals the immediate-select bit instr[22]. `imm_value` is instr[8:0] zero-extended to 32 bits.
- R3: The condition field is instr[21:18]. The instruction executes (`exec_go` high) exactly when condition bit number {C,Z} is set, where C and Z are `flag_c` and `flag_z`. For example, bit 1 covers C=0, Z=1.
- R4: Condition 4'b0000 never executes, whatever the flags. Condition 4'b1111 always executes.
- R5: `wb_strobe` is high only when the instruction executes and its writeback bit instr[23] is set.
- R6: `z_next` equals `alu_z` when the instruction executes and its Zero-update bit instr[25] is set. Otherwise `z_next` equals `flag_z`.
- R7: `c_next` equals `alu_c` when the instruction executes and its Carry-update bit instr[24] is set. Otherwise `c_next` equals `flag_c`. This holds independently of the Zero-update bit.
- R8: A skipped instruction updates neither flag, writes nothing, and reports `skip_cycles` = 4. An executed instruction reports `skip_cycles` = 0.
- R9: While `rst` is high, `out_valid`, `exec_go`, `wb_strobe`, `z_next`, `c_next` and `skip_cycles` are cleared on the next clock.
- R10: One clock after `in_valid` is low, `out_valid`, `exec_go` and `wb_strobe` are low and `skip_cycles` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| flag_z | input | 1 | Current Zero flag |
| flag_c | input | 1 | Current Carry flag |
| alu_z | input | 1 | Zero result from the ALU |
| alu_c | input | 1 | Carry result from the ALU |
| out_valid | output | 1 | Registered outputs describe an instruction |
| opcode | output | 6 | Operation code |
| dest_addr | output | 9 | Destination register address |
| src_addr | output | 9 | Source register address |
| src_is_imm | output | 1 | Use immediate instead of source register |
| imm_value | output | 32 | Zero-extended immediate |
| exec_go | output | 1 | Instruction executes |
| wb_strobe | output | 1 | Write result to destination register |
| z_next | output | 1 | Next Zero flag |
| c_next | output | 1 | Next Carry flag |
| skip_cycles | output | 3 | Clocks consumed by a skipped instruction |

## Verification
A single instruction can ask for a register writeback and both flag updates while its condition fails. The skip decision and the commit enables are therefore resolved in the same cycle. The bench provokes this with vectors that set all three enable bits under a condition that does not match the flags. It drives ALU flags that differ from the current flags. It then judges that `wb_strobe` stays low, that `z_next` and `c_next` repeat the incoming flags, and that `skip_cycles` reads 4. Matching vectors with a passing condition show the same enables taking effect, and one vector enables only one flag to show the two updates are separate.

// File: rtl/cxc_pkg.sv
package cxc_pkg;
  localparam int WORD_W  = 32;
  localparam int OPC_W   = 6;
  localparam int REG_AW  = 9;
  localparam int FLAG_N  = 2;               // index 0 = Zero, 1 = Carry
  localparam int COND_W  = 1 << FLAG_N;

  localparam int SRC_LSB  = 0;
  localparam int DST_LSB  = SRC_LSB + REG_AW;
  localparam int COND_LSB = DST_LSB + REG_AW;
  localparam int IMM_BIT  = COND_LSB + COND_W;
  localparam int WB_BIT   = IMM_BIT + 1;
  localparam int CEN_BIT  = WB_BIT + 1;
  localparam int ZEN_BIT  = CEN_BIT + 1;
  localparam int OPC_LSB  = ZEN_BIT + 1;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [FLAG_N-1:0] flag_en;   // [1] carry, [0] zero
    logic              wb_en;
    logic              use_imm;
    logic [COND_W-1:0] cond;
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] src;
  } ins_fields_t;
endpackage

// File: rtl/cxc_field_split.sv
module cxc_field_split
  import cxc_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output ins_fields_t       fields
);
  always_comb begin
    fields.opc        = word[OPC_LSB +: OPC_W];
    fields.flag_en[0] = word[ZEN_BIT];
    fields.flag_en[1] = word[CEN_BIT];
    fields.wb_en      = word[WB_BIT];
    fields.use_imm    = word[IMM_BIT];
    fields.cond       = word[COND_LSB +: COND_W];
    fields.dst        = word[DST_LSB +: REG_AW];
    fields.src        = word[SRC_LSB +: REG_AW];
  end
endmodule

// File: rtl/cxc_cond_eval.sv
module cxc_cond_eval
  import cxc_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic [FLAG_N-1:0] flags,   // {carry, zero}
  output logic              pass
);
  always_comb pass = cond[flags];
endmodule

// File: rtl/cxc_flag_merge.sv
module cxc_flag_merge
  import cxc_pkg::*;
(
  input  logic              go,
  input  logic [FLAG_N-1:0] enable,
  input  logic [FLAG_N-1:0] current,
  input  logic [FLAG_N-1:0] result,
  output logic [FLAG_N-1:0] merged
);
  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    always_comb merged[g] = (go && enable[g]) ? result[g] : current[g];
  end
endmodule

// File: rtl/cond_exec_ctrl.sv
module cond_exec_ctrl
  import cxc_pkg::*;
#(
  parameter  int SKIP_CLOCKS = 4,
  localparam int SKIP_W      = $clog2(SKIP_CLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] instr,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              alu_z,
  input  logic              alu_c,
  output logic              out_valid,
  output logic [OPC_W-1:0]  opcode,
  output logic [REG_AW-1:0] dest_addr,
  output logic [REG_AW-1:0] src_addr,
  output logic              src_is_imm,
  output logic [WORD_W-1:0] imm_value,
  output logic              exec_go,
  output logic              wb_strobe,
  output logic              z_next,
  output logic              c_next,
  output logic [SKIP_W-1:0] skip_cycles
);
  localparam logic [SKIP_W-1:0] SKIP_VAL = SKIP_W'(SKIP_CLOCKS);

  ins_fields_t       fld;
  logic              cond_ok;
  logic              go;
  logic [FLAG_N-1:0] cur_flags;
  logic [FLAG_N-1:0] alu_flags;
  logic [FLAG_N-1:0] nxt_flags;

  assign cur_flags = {flag_c, flag_z};
  assign alu_flags = {alu_c, alu_z};
  assign go        = in_valid && cond_ok;

  cxc_field_split u_split (
    .word   (instr),
    .fields (fld)
  );

  cxc_cond_eval u_cond (
    .cond  (fld.cond),
    .flags (cur_flags),
    .pass  (cond_ok)
  );

  cxc_flag_merge u_merge (
    .go      (go),
    .enable  (fld.flag_en),
    .current (cur_flags),
    .result  (alu_flags),
    .merged  (nxt_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      opcode      <= '0;
      dest_addr   <= '0;
      src_addr    <= '0;
      src_is_imm  <= 1'b0;
      imm_value   <= '0;
      exec_go     <= 1'b0;
      wb_strobe   <= 1'b0;
      z_next      <= 1'b0;
      c_next      <= 1'b0;
      skip_cycles <= '0;
    end else begin
      out_valid   <= in_valid;
      opcode      <= fld.opc;
      dest_addr   <= fld.dst;
      src_addr    <= fld.src;
      src_is_imm  <= fld.use_imm;
      imm_value   <= WORD_W'(fld.src);
      exec_go     <= go;
      wb_strobe   <= go && fld.wb_en;
      z_next      <= nxt_flags[0];
      c_next      <= nxt_flags[1];
      skip_cycles <= (in_valid && !cond_ok) ? SKIP_VAL : '0;
    end
  end
endmodule

// File: rtl/cond_exec_ctrl_chk.sv
module cond_exec_ctrl_chk
  import cxc_pkg::*;
#(
  parameter int SKIP_CLOCKS = 4,
  parameter int SKIP_W      = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [WORD_W-1:0] instr,
  input logic              flag_z,
  input logic              flag_c,
  input logic              alu_z,
  input logic              alu_c,
  input logic              out_valid,
  input logic [OPC_W-1:0]  opcode,
  input logic [REG_AW-1:0] dest_addr,
  input logic [REG_AW-1:0] src_addr,
  input logic              src_is_imm,
  input logic [WORD_W-1:0] imm_value,
  input logic              exec_go,
  input logic              wb_strobe,
  input logic              z_next,
  input logic              c_next,
  input logic [SKIP_W-1:0] skip_cycles
);
  p_fields_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (opcode == $past(instr[31:26]) && dest_addr == $past(instr[17:9])
                   && src_addr == $past(instr[8:0])));

  p_imm_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (src_is_imm == $past(instr[22])
                   && imm_value == {{(WORD_W-REG_AW){1'b0}}, $past(instr[8:0])}));

  p_never_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && in_valid && instr[21:18] == 4'b0000) |-> !exec_go);

  p_always_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && in_valid && instr[21:18] == 4'b1111) |-> exec_go);

  p_wb_gate_r5: assert property (@(posedge clk) disable iff (rst)
    wb_strobe |-> (exec_go && $past(instr[23])));

  p_zero_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !exec_go) |-> z_next == $past(flag_z));

  p_carry_upd_r7: assert property (@(posedge clk) disable iff (rst)
    (exec_go && $past(instr[24])) |-> c_next == $past(alu_c));

  p_skip_cost_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !exec_go) |-> (skip_cycles == SKIP_W'(SKIP_CLOCKS) && !wb_strobe));

  p_reset_r9: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !exec_go && !wb_strobe && skip_cycles == '0));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> (!out_valid && !exec_go && !wb_strobe && skip_cycles == '0));
endmodule

bind cond_exec_ctrl cond_exec_ctrl_chk #(
  .SKIP_CLOCKS (SKIP_CLOCKS),
  .SKIP_W      (SKIP_W)
) u_chk (.*);

// File: tb/test_cond_exec_ctrl.sv
`timescale 1ns/1ps
module test_cond_exec_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic        flag_z = 1'b0, flag_c = 1'b0, alu_z = 1'b0, alu_c = 1'b0;
  logic        out_valid, src_is_imm, exec_go, wb_strobe, z_next, c_next;
  logic [5:0]  opcode;
  logic [8:0]  dest_addr, src_addr;
  logic [31:0] imm_value;
  logic [2:0]  skip_cycles;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cond_exec_ctrl i_cond_exec_ctrl (.*);

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic ze, input logic ce,
                                     input logic we, input logic im, input logic [3:0] cnd,
                                     input logic [8:0] d, input logic [8:0] s);
    return {opc, ze, ce, we, im, cnd, d, s};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic fz, fc, az, ac;
    logic ex, wb, zn, cn;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{mk(6'h21,1,1,1,0,4'b1111,9'h1A5,9'h03C), 0,0,1,1, 1,1,1,1}, // always
    '{mk(6'h05,1,1,1,0,4'b0000,9'h011,9'h022), 0,1,1,0, 0,0,0,1}, // never, all enables
    '{mk(6'h3F,1,0,0,0,4'b0010,9'h100,9'h0FF), 1,0,0,1, 1,0,0,0}, // Z only, no wb
    '{mk(6'h10,1,1,1,0,4'b0010,9'h0AA,9'h155), 0,1,1,0, 0,0,0,1}, // fails, all enables
    '{mk(6'h2A,0,1,1,1,4'b0100,9'h1FF,9'h1FF), 0,1,1,0, 1,1,0,0}, // C only, imm
    '{mk(6'h00,1,0,1,0,4'b1000,9'h000,9'h001), 1,1,0,0, 1,1,0,1}, // idx3
    '{mk(6'h15,1,1,1,1,4'b0111,9'h123,9'h080), 1,1,0,0, 0,0,1,1}, // fails idx3
    '{mk(6'h0C,0,0,1,0,4'b0001,9'h055,9'h0AA), 0,0,1,1, 1,1,0,0}, // idx0, no flag en
    '{mk(6'h33,1,1,1,0,4'b1110,9'h0F0,9'h00F), 0,0,1,1, 0,0,0,0}  // fails idx0
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk);
    chk("R9", "out_valid", out_valid, 0);
    chk("R9", "exec_go", exec_go, 0);
    chk("R9", "wb_strobe", wb_strobe, 0);
    chk("R9", "flags", {z_next, c_next}, 0);
    chk("R9", "skip_cycles", skip_cycles, 0);
    rst = 1'b0;

    // Vector walk: one instruction per cycle, results one cycle later
    for (int k = 0; k < NV; k++) begin
      instr = VEC[k].ins; flag_z = VEC[k].fz; flag_c = VEC[k].fc;
      alu_z = VEC[k].az;  alu_c = VEC[k].ac;  in_valid = 1'b1;
      @(negedge clk);
      chk("R1", "out_valid", out_valid, 1);
      chk("R1", "opcode", opcode, VEC[k].ins[31:26]);
      chk("R1", "dest_addr", dest_addr, VEC[k].ins[17:9]);
      chk("R1", "src_addr", src_addr, VEC[k].ins[8:0]);
      chk("R2", "src_is_imm", src_is_imm, VEC[k].ins[22]);
      chk("R2", "imm_value", imm_value, {23'b0, VEC[k].ins[8:0]});
      chk(VEC[k].ins[21:18] inside {4'b0000, 4'b1111} ? "R4" : "R3", "exec_go",
          exec_go, VEC[k].ex);
      chk("R5", "wb_strobe", wb_strobe, VEC[k].wb);
      chk("R6", "z_next", z_next, VEC[k].zn);
      chk("R7", "c_next", c_next, VEC[k].cn);
      chk("R8", "skip_cycles", skip_cycles, VEC[k].ex ? 0 : 4);
    end

    // R10: idle cycle after a passing, writing instruction
    instr = VEC[0].ins; flag_z = 0; flag_c = 0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10", "out_valid", out_valid, 0);
    chk("R10", "exec_go", exec_go, 0);
    chk("R10", "wb_strobe", wb_strobe, 0);
    chk("R10", "skip_cycles", skip_cycles, 0);

    // R4: never-code under every flag combination; always-code likewise
    for (int f = 0; f < 4; f++) begin
      instr = mk(6'h01, 1, 1, 1, 0, 4'b0000, 9'h001, 9'h002);
      {flag_c, flag_z} = 2'(f); alu_z = ~flag_z; alu_c = ~flag_c; in_valid = 1'b1;
      @(negedge clk);
      chk("R4", "never exec_go", exec_go, 0);
      chk("R8", "never flags held", {z_next, c_next}, {flag_z, flag_c});
      instr = mk(6'h01, 0, 0, 1, 0, 4'b1111, 9'h001, 9'h002);
      @(negedge clk);
      chk("R4", "always exec_go", exec_go, 1);
    end

    // R9: reset while an instruction is presented
    instr = VEC[0].ins; flag_z = 0; flag_c = 0; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    chk("R9", "mid-run out_valid", out_valid, 0);
    chk("R9", "mid-run wb_strobe", wb_strobe, 0);
    chk("R9", "mid-run exec_go", exec_go, 0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule